// File: doc/BRIEF.md
# Reloading Interval Timer Unit

This block holds two counters behind a small register port. The first is a 16-bit down-counter that reloads itself from a programmable load register. Each time it passes zero it sets a latched interrupt flag, which drives the `irq` output. The second is a 40-bit up-counter that runs freely when enabled and never interrupts. Software reads it to measure elapsed time at a finer grain than the periodic interrupt gives.

Neither counter divides a clock itself. The surrounding chip supplies one-cycle clock-enable strobes at the nominal rates: `tick_fast` at about 508 kHz, `tick_slow` as the alternative rate for the reload counter, and `tick_free` at 983.04 kHz. The usual setup has four steps. Write N-1 to the load register for a period of N ticks. Write the control byte with the enable bit clear. Write it again with the enable bit set. Write anything to the clear register from the interrupt handler. The free counter wraps silently at its maximum value.

The register port is single-cycle. A write takes effect at the clock edge where `bus_we` is high. A read registers its data one cycle after `bus_re` and marks it with `bus_rvalid`.

Top module: `ivt_unit`

## Requirements
- R1: After synchronous reset every readable register reads 0, both counters are 0, and `irq` is low.
- R2: Control register (offset 2) bit 7 enables the reload counter, bit 6 selects periodic mode, and bit 3 selects the rate. Only these three bits are stored; the others read back as 0. The write that turns bit 7 from 0 to 1 copies the load register into the count.
- R3: While enabled, each strobe of the selected rate lowers a nonzero count by exactly one at that clock edge.
- R4: In periodic mode, a selected strobe at count 0 reloads the count from the load register and sets the interrupt flag at the same edge.
- R5: `irq` is the latched underflow flag. It stays high until a write of any value to the clear register (offset 3) lowers it.
- R6: If a clear write and an underflow fall in the same cycle, the flag stays set.
- R7: A load register (offset 0) write while the counter runs leaves the current count alone. The new value is used at the next reload.
- R8: While disabled, the count holds and ignores every strobe.
- R9: With bit 6 clear, a selected strobe at count 0 sets the count to all ones (0xFFFF) and sets the flag.
- R10: Control bit 3 = 1 makes `tick_fast` the decrement strobe, and bit 3 = 0 makes `tick_slow` the decrement strobe. The strobe that is not selected has no effect.
- R11: The free counter (low 32 bits at offset 4) counts `tick_free` strobes only while bit 8 of its high register (offset 5) is set. It holds its value otherwise. The high register reads the enable in bit 8 and count bits 39:32 in bits 7:0. Writes to the high register change only the enable.
- R12: A read at offset 0, 1, 2, 4 or 5 returns, one cycle after `bus_re`, the load register, the current count, the control byte, the free low word or the free high word. `bus_rvalid` is high in that cycle only. Offset 3 and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Fast-rate strobe for the reload counter |
| tick_slow | input | 1 | Slow-rate strobe for the reload counter |
| tick_free | input | 1 | Strobe for the free-running counter |
| bus_we | input | 1 | Register write request |
| bus_re | input | 1 | Register read request |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_re` |
| irq | output | 1 | Latched underflow interrupt |

## Verification
The reload counter is driven with three kinds of input.

- Fast-rate strobe trains against slow-rate strobe trains, under both settings of the rate bit. This shows which strobe is actually selected.
- Strobes while disabled. These show that enabling is what copies the load value, and that ticks are not counted ahead of it.
- A load write in the middle of a run, and a clear write in the same cycle as an underflow. These separate the current count from the reload value, and the clear from the set.

Periodic and non-periodic underflow are compared by the count value that follows zero. The free counter is strobed both before and after its enable bit toggles, to show that it holds and then counts.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W = 3;
  localparam int CTL_EN   = 7;
  localparam int CTL_PER  = 6;
  localparam int CTL_RATE = 3;
  localparam int FHI_EN   = 8;
  localparam logic [7:0] CTL_MASK = 8'hC8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_LOAD  = 3'd0,
    OFS_COUNT = 3'd1,
    OFS_CTRL  = 3'd2,
    OFS_CLEAR = 3'd3,
    OFS_FLO   = 3'd4,
    OFS_FHI   = 3'd5
  } reg_ofs_e;
endpackage

// File: rtl/ivt_reload_ctr.sv
module ivt_reload_ctr
  import ivt_pkg::*;
#(
  parameter int RLD_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              load_we,
  input  logic              ctrl_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [RLD_W-1:0]  load_q,
  output logic [RLD_W-1:0]  count_q,
  output logic [7:0]        ctrl_q,
  output logic              irq_q
);
  logic en, periodic, tick_sel, step, start, underflow;

  assign en        = ctrl_q[CTL_EN];
  assign periodic  = ctrl_q[CTL_PER];
  assign tick_sel  = ctrl_q[CTL_RATE] ? tick_fast : tick_slow;
  assign step      = en & tick_sel;
  assign start     = ctrl_we & wdata[CTL_EN] & ~en;
  assign underflow = step & (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (load_we) load_q <= wdata[RLD_W-1:0];
      if (ctrl_we) ctrl_q <= wdata[7:0] & CTL_MASK;
      if (start) begin
        count_q <= load_q;
      end else if (step) begin
        if (count_q == '0) count_q <= periodic ? load_q : '1;
        else               count_q <= count_q - 1'b1;
      end
      if (underflow)   irq_q <= 1'b1;
      else if (clr_we) irq_q <= 1'b0;
    end
  end

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!en && !ctrl_we) |=> $stable(count_q));
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (step && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (step && count_q == '0 && periodic) |=> (count_q == $past(load_q)) && irq_q);
  a_r9_wrap_ones: assert property (@(posedge clk) disable iff (rst)
    (step && count_q == '0 && !periodic) |=> (&count_q) && irq_q);
  a_r6_clear_race: assert property (@(posedge clk) disable iff (rst)
    (underflow && clr_we) |=> irq_q);
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_we) |=> irq_q);
endmodule

// File: rtl/ivt_free_ctr.sv
module ivt_free_ctr
  import ivt_pkg::*;
#(
  parameter int FREE_W = 40,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_free,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lo_word,
  output logic [DATA_W-1:0] hi_word
);
  localparam int HI_W = FREE_W - DATA_W;

  logic [FREE_W-1:0] cnt_q;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (hi_we) en_q <= wdata[FHI_EN];
      if (en_q && tick_free) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lo_word = cnt_q[DATA_W-1:0];

  generate
    if (HI_W > 0) begin : g_hi
      always_comb begin
        hi_word = '0;
        hi_word[HI_W-1:0] = cnt_q[FREE_W-1:DATA_W];
        hi_word[FHI_EN] = en_q;
      end
    end else begin : g_nohi
      always_comb begin
        hi_word = '0;
        hi_word[FHI_EN] = en_q;
      end
    end
  endgenerate

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(cnt_q));
  a_r11_count: assert property (@(posedge clk) disable iff (rst)
    (en_q && tick_free) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ivt_bus_if.sv
module ivt_bus_if
  import ivt_pkg::*;
#(
  parameter int RLD_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [RLD_W-1:0]  load_q,
  input  logic [RLD_W-1:0]  count_q,
  input  logic [7:0]        ctrl_q,
  input  logic [DATA_W-1:0] free_lo,
  input  logic [DATA_W-1:0] free_hi,
  output logic              load_we,
  output logic              ctrl_we,
  output logic              clr_we,
  output logic              fhi_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  logic [DATA_W-1:0] rd_mux;

  assign load_we = bus_we && bus_addr == OFS_LOAD;
  assign ctrl_we = bus_we && bus_addr == OFS_CTRL;
  assign clr_we  = bus_we && bus_addr == OFS_CLEAR;
  assign fhi_we  = bus_we && bus_addr == OFS_FHI;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_LOAD:  rd_mux[RLD_W-1:0] = load_q;
      OFS_COUNT: rd_mux[RLD_W-1:0] = count_q;
      OFS_CTRL:  rd_mux[7:0]       = ctrl_q;
      OFS_FLO:   rd_mux            = free_lo;
      OFS_FHI:   rd_mux            = free_hi;
      default:   rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  a_r12_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid);
  a_r12_rvalid_only: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> !bus_rvalid);
endmodule

// File: rtl/ivt_unit.sv
module ivt_unit
  import ivt_pkg::*;
#(
  parameter int RLD_W  = 16,
  parameter int FREE_W = 40,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              tick_free,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  logic              load_we, ctrl_we, clr_we, fhi_we;
  logic [RLD_W-1:0]  load_q, count_q;
  logic [7:0]        ctrl_q;
  logic [DATA_W-1:0] free_lo, free_hi;

  ivt_bus_if #(.RLD_W(RLD_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .load_q(load_q), .count_q(count_q),
    .ctrl_q(ctrl_q), .free_lo(free_lo), .free_hi(free_hi),
    .load_we(load_we), .ctrl_we(ctrl_we), .clr_we(clr_we),
    .fhi_we(fhi_we), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  ivt_reload_ctr #(.RLD_W(RLD_W), .DATA_W(DATA_W)) u_reload (
    .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .load_we(load_we), .ctrl_we(ctrl_we), .clr_we(clr_we),
    .wdata(bus_wdata), .load_q(load_q), .count_q(count_q),
    .ctrl_q(ctrl_q), .irq_q(irq)
  );

  ivt_free_ctr #(.FREE_W(FREE_W), .DATA_W(DATA_W)) u_free (
    .clk(clk), .rst(rst), .tick_free(tick_free), .hi_we(fhi_we),
    .wdata(bus_wdata), .lo_word(free_lo), .hi_word(free_hi)
  );

  a_r1_irq_reset: assert property (@(posedge clk) rst |=> !irq);
endmodule

// File: tb/ivt_unit_tb.sv
module ivt_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_fast = 0, tick_slow = 0, tick_free = 0;
  logic        bus_we = 0, bus_re = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] exp;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  ivt_unit u_dut (
    .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .tick_free(tick_free), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R12: unexpected read response 0x%0h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    e.tag = tag; e.exp = exp;
    sb_q.push_back(e);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse(int which, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which == 0) tick_fast = 1'b1;
      else if (which == 1) tick_slow = 1'b1;
      else tick_free = 1'b1;
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0; tick_free = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 / R12 reset state and read map
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
    rd(3'd0, 32'd0, "R1 load reset");
    rd(3'd1, 32'd0, "R1 count reset");
    rd(3'd2, 32'd0, "R1 ctrl reset");
    rd(3'd4, 32'd0, "R1 free low reset");
    rd(3'd5, 32'd0, "R12 free high reset");
    // R8 disabled: ticks ignored, load pending
    wr(3'd0, 32'd4);
    wr(3'd2, 32'h48);
    pulse(0, 3);
    rd(3'd1, 32'd0, "R8 count holds while disabled");
    rd(3'd0, 32'd4, "R12 load readback");
    // R2 enable copies load, ctrl masked readback
    wr(3'd2, 32'hFF);
    rd(3'd1, 32'd4, "R2 enable loads count");
    rd(3'd2, 32'hC8, "R2 ctrl readback masked");
    rd(3'd3, 32'd0, "R12 clear reg reads zero");
    rd(3'd7, 32'd0, "R12 unused offset reads zero");
    // R3 / R10 decrement on selected strobe only
    pulse(0, 1);
    rd(3'd1, 32'd3, "R3 one fast tick");
    pulse(1, 2);
    rd(3'd1, 32'd3, "R10 slow strobe ignored at rate=1");
    pulse(0, 3);
    rd(3'd1, 32'd0, "R3 reach zero");
    check("R4 no irq before underflow", {31'b0, irq}, 32'd0);
    // R4 periodic reload
    pulse(0, 1);
    check("R4 irq at underflow", {31'b0, irq}, 32'd1);
    rd(3'd1, 32'd4, "R4 reload value");
    pulse(0, 2);
    check("R5 irq held", {31'b0, irq}, 32'd1);
    wr(3'd3, 32'h0);
    check("R5 irq cleared", {31'b0, irq}, 32'd0);
    // R7 load write mid-run
    wr(3'd0, 32'd6);
    rd(3'd1, 32'd2, "R7 count unchanged by load write");
    pulse(0, 2);
    check("R7 no irq yet", {31'b0, irq}, 32'd0);
    pulse(0, 1);
    rd(3'd1, 32'd6, "R7 new load at reload");
    wr(3'd3, 32'h0);
    // R6 clear races underflow
    pulse(0, 6);
    rd(3'd1, 32'd0, "R6 at zero");
    @(negedge clk);
    tick_fast = 1'b1; bus_we = 1'b1; bus_addr = 3'd3;
    @(negedge clk);
    tick_fast = 1'b0; bus_we = 1'b0;
    check("R6 flag kept on clear race", {31'b0, irq}, 32'd1);
    wr(3'd3, 32'h0);
    check("R5 clear after race", {31'b0, irq}, 32'd0);
    // R10 slow rate
    wr(3'd2, 32'hC0);
    pulse(0, 2);
    rd(3'd1, 32'd6, "R10 fast ignored at rate=0");
    pulse(1, 2);
    rd(3'd1, 32'd4, "R10 slow ticks counted");
    // R9 non-periodic wrap
    wr(3'd2, 32'h00);
    wr(3'd0, 32'd0);
    wr(3'd2, 32'h88);
    rd(3'd1, 32'd0, "R2 enable loads zero");
    pulse(0, 1);
    check("R9 irq on wrap", {31'b0, irq}, 32'd1);
    rd(3'd1, 32'hFFFF, "R9 wraps to all ones");
    pulse(0, 1);
    rd(3'd1, 32'hFFFE, "R9 keeps counting");
    // R11 free counter
    pulse(2, 3);
    rd(3'd4, 32'd0, "R11 free holds while disabled");
    wr(3'd5, 32'h100);
    rd(3'd5, 32'h100, "R11 high reads enable");
    pulse(2, 5);
    rd(3'd4, 32'd5, "R11 free counts strobes");
    pulse(0, 2);
    rd(3'd4, 32'd5, "R11 other strobes ignored");
    wr(3'd5, 32'h0FF);
    pulse(2, 2);
    rd(3'd4, 32'd5, "R11 free holds after disable");
    rd(3'd5, 32'h0, "R11 high write changes only enable");
    repeat (3) @(negedge clk);
    check("R12 all responses seen", sb_q.size(), 32'd0);
    finish_run();
  end
endmodule